// File: doc/BRIEF.md
# Write Leveling Calibration Sequencer

This block calibrates the strobe launch delay of every byte lane of one rank in a fly-by memory channel. Each lane has one strobe pair and its data bits. A start request names the rank and a settle time. The block first asks the command path for a mode-register write that turns leveling on for that rank. It then sweeps a shared strobe delay tap from 0 to 127, where one tap is 1/128 of a clock period. At each tap it waits for the delay to settle and then fires five strobe pulses. For each pulse it samples the one-bit feedback that each lane's memory returns, which is the memory clock as captured by the arriving strobe.

Each lane makes up its own mind. A majority vote over the five samples turns the feedback at a tap into one bit. The alignment point is the first tap where that bit goes from low to high. The programmed delay is that tap plus a quarter period (32 taps), wrapped to 7 bits. A lane that never sees a rising transition is marked failed and gets delay zero. When the sweep ends, the final taps are written into a per-rank result memory and driven on the tap outputs. A second mode-register write then turns leveling off, and a one-cycle done pulse reports completion together with an overall fail flag and a per-lane fail vector.

Top module: `wrlvl_seq`

## Requirements
- R1: After reset, mrw_req, strobe_pulse, busy, done, fail, lane_fail and every tap_out lane are 0.
- R2: A cal_start in idle raises mrw_req with mrw_lvl_on=1 and mrw_rank equal to cal_rank. mrw_req stays high until the cycle mrw_ack is sampled high. No strobe pulse occurs before that acknowledge.
- R3: The sweep visits taps 0 to 127 in increasing order. All lanes of tap_out show the sweep tap, and it is stable while strobe_pulse is high. Each tap gets exactly 5 consecutive strobe_pulse cycles, so one run has 640 pulses. After a tap change, the first pulse comes no sooner than settle_cycles cycles later.
- R4: dq_fb is sampled in every cycle where strobe_pulse is high. A lane's bit for a tap is 1 when at least 3 of its 5 samples are 1, so up to 2 contrary samples are outvoted.
- R5: A lane's alignment tap is the lowest tap t (t ≥ 1) whose voted bit is 1 while the bit at t−1 is 0. A high bit at tap 0 is not a transition, and later transitions are ignored.
- R6: A lane's final delay is (alignment tap + 32) mod 128. A tap of 110 therefore gives 14.
- R7: A lane with no transition sets its bit of lane_fail (bit i is lane i) and gets final delay 0. fail is high with done whenever any lane failed.
- R8: Lanes are decided independently; each uses only its own dq_fb bit.
- R9: rd_taps shows, one cycle after rd_rank is presented, the final delays last stored for that rank, with lane i at bits [7i+6:7i]. A run on one rank leaves the other ranks' stored results unchanged.
- R10: After the sweep, mrw_req rises with mrw_lvl_on=0 for the same rank. done is a single-cycle pulse in the cycle after that request is acknowledged. From the store step until the next start, tap_out holds the final delays.
- R11: cal_start while busy is ignored: the run in progress keeps its rank and results and issues only its own two mode-register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Start request, taken only when idle |
| cal_rank | input | 1 | Rank to level |
| settle_cycles | input | 8 | Wait cycles after each tap change |
| mrw_req | output | 1 | Mode-register write request |
| mrw_lvl_on | output | 1 | 1 = enter leveling, 0 = exit leveling |
| mrw_rank | output | 1 | Rank addressed by the mode-register write |
| mrw_ack | input | 1 | Command path accepted the request |
| strobe_pulse | output | 1 | Strobe pulse fired this cycle; feedback sampled |
| tap_out | output | 14 | Strobe delay tap per lane, 7 bits each |
| dq_fb | input | 2 | Leveling feedback bit per lane |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | At least one lane failed, valid with done |
| lane_fail | output | 2 | Per-lane failure flags |
| rd_rank | input | 1 | Rank selected for result readback |
| rd_taps | output | 14 | Stored final taps of rd_rank, one cycle later |

## Verification
Each result has a fixed point at which it is due. Feedback must be valid in the same cycle strobe_pulse is high, so the feedback model advances its pulse index only at the rising edge that follows that cycle. The final delays, lane_fail and fail are due in the done cycle, which is the cycle after the exit write is acknowledged. The monitor therefore pops an expected item only when it sees done at a falling edge. Readback data is compared one full cycle after rd_rank changes. Tap order, pulse count and settle gap are measured at falling edges, relative to the cycle in which tap_out last changed.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;
  typedef enum logic [2:0] {
    WL_IDLE,
    WL_MRW_ON,
    WL_SETTLE,
    WL_PULSE,
    WL_EVAL,
    WL_STORE,
    WL_MRW_OFF
  } wl_state_t;
endpackage

// File: rtl/wrlvl_lane.sv
module wrlvl_lane #(
  parameter int TAP_W = 7,
  parameter int VOTES = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic             eval,
  input  logic             fb,
  input  logic [TAP_W-1:0] tap,
  output logic             found,
  output logic [TAP_W-1:0] final_tap
);
  localparam int CNT_W = $clog2(VOTES + 1);
  localparam int MAJ   = VOTES / 2 + 1;
  localparam int TAPS  = 1 << TAP_W;
  localparam logic [TAP_W-1:0] QTR = TAP_W'(TAPS / 4);

  logic [CNT_W-1:0] ones_q;
  logic             prev_q;
  logic             found_q;
  logic [TAP_W-1:0] ftap_q;
  logic             vote;

  assign vote = (ones_q >= CNT_W'(MAJ));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ones_q  <= '0;
      prev_q  <= 1'b1;
      found_q <= 1'b0;
      ftap_q  <= '0;
    end else if (eval) begin
      if (!found_q && !prev_q && vote) begin
        found_q <= 1'b1;
        ftap_q  <= tap;
      end
      prev_q <= vote;
      ones_q <= '0;
    end else if (sample) begin
      ones_q <= ones_q + CNT_W'(fb);
    end
  end

  assign found     = found_q;
  assign final_tap = found_q ? (ftap_q + QTR) : '0;

  // R5
  found_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (found_q && !clear) |=> found_q);

  // R4
  votes_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ones_q <= CNT_W'(VOTES));
endmodule

// File: rtl/wrlvl_store.sv
module wrlvl_store #(
  parameter int NUM_RANKS = 2,
  parameter int DATA_W    = 14
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [$clog2(NUM_RANKS)-1:0] waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [$clog2(NUM_RANKS)-1:0] raddr,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] mem [NUM_RANKS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wrlvl_seq.sv
module wrlvl_seq
  import wrlvl_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int NUM_RANKS = 2,
  parameter int TAP_W     = 7,
  parameter int VOTES     = 5,
  parameter int SETTLE_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cal_start,
  input  logic [$clog2(NUM_RANKS)-1:0] cal_rank,
  input  logic [SETTLE_W-1:0]          settle_cycles,
  output logic                         mrw_req,
  output logic                         mrw_lvl_on,
  output logic [$clog2(NUM_RANKS)-1:0] mrw_rank,
  input  logic                         mrw_ack,
  output logic                         strobe_pulse,
  output logic [NUM_LANES*TAP_W-1:0]   tap_out,
  input  logic [NUM_LANES-1:0]         dq_fb,
  output logic                         busy,
  output logic                         done,
  output logic                         fail,
  output logic [NUM_LANES-1:0]         lane_fail,
  input  logic [$clog2(NUM_RANKS)-1:0] rd_rank,
  output logic [NUM_LANES*TAP_W-1:0]   rd_taps
);
  localparam int RANK_W = $clog2(NUM_RANKS);
  localparam int BUS_W  = NUM_LANES * TAP_W;
  localparam int PC_W   = $clog2(VOTES);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  wl_state_t             state;
  logic [TAP_W-1:0]      tap_q;
  logic [RANK_W-1:0]     rank_q;
  logic [SETTLE_W-1:0]   settle_q;
  logic [SETTLE_W-1:0]   cnt_q;
  logic [PC_W-1:0]       pcnt_q;
  logic                  req_q;
  logic                  lvl_q;
  logic                  done_q;
  logic                  fail_q;
  logic [NUM_LANES-1:0]  lfail_q;
  logic [BUS_W-1:0]      tap_out_q;
  logic [BUS_W-1:0]      final_bus;
  logic [NUM_LANES-1:0]  found_bus;
  logic                  lane_clear;
  logic [TAP_W-1:0]      tap_nx;

  assign lane_clear = (state == WL_IDLE) && cal_start;
  assign tap_nx     = tap_q + 1'b1;

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : g_lane
      wrlvl_lane #(.TAP_W(TAP_W), .VOTES(VOTES)) lane_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (lane_clear),
        .sample   (state == WL_PULSE),
        .eval     (state == WL_EVAL),
        .fb       (dq_fb[g]),
        .tap      (tap_q),
        .found    (found_bus[g]),
        .final_tap(final_bus[g*TAP_W +: TAP_W])
      );
    end
  endgenerate

  wrlvl_store #(.NUM_RANKS(NUM_RANKS), .DATA_W(BUS_W)) store_i (
    .clk  (clk),
    .we   (state == WL_STORE),
    .waddr(rank_q),
    .wdata(final_bus),
    .raddr(rd_rank),
    .rdata(rd_taps)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WL_IDLE;
      tap_q     <= '0;
      rank_q    <= '0;
      settle_q  <= '0;
      cnt_q     <= '0;
      pcnt_q    <= '0;
      req_q     <= 1'b0;
      lvl_q     <= 1'b0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      lfail_q   <= '0;
      tap_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        WL_IDLE: begin
          if (cal_start) begin
            rank_q    <= cal_rank;
            settle_q  <= settle_cycles;
            tap_q     <= '0;
            tap_out_q <= '0;
            lfail_q   <= '0;
            fail_q    <= 1'b0;
            req_q     <= 1'b1;
            lvl_q     <= 1'b1;
            state     <= WL_MRW_ON;
          end
        end
        WL_MRW_ON: begin
          if (mrw_ack) begin
            req_q <= 1'b0;
            cnt_q <= '0;
            state <= WL_SETTLE;
          end
        end
        WL_SETTLE: begin
          if (cnt_q >= settle_q) begin
            pcnt_q <= '0;
            state  <= WL_PULSE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        WL_PULSE: begin
          if (pcnt_q == PC_W'(VOTES - 1)) state <= WL_EVAL;
          else pcnt_q <= pcnt_q + 1'b1;
        end
        WL_EVAL: begin
          if (tap_q == TAP_MAX) begin
            state <= WL_STORE;
          end else begin
            tap_q     <= tap_nx;
            tap_out_q <= {NUM_LANES{tap_nx}};
            cnt_q     <= '0;
            state     <= WL_SETTLE;
          end
        end
        WL_STORE: begin
          tap_out_q <= final_bus;
          lfail_q   <= ~found_bus;
          req_q     <= 1'b1;
          lvl_q     <= 1'b0;
          state     <= WL_MRW_OFF;
        end
        WL_MRW_OFF: begin
          if (mrw_ack) begin
            req_q  <= 1'b0;
            done_q <= 1'b1;
            fail_q <= |lfail_q;
            state  <= WL_IDLE;
          end
        end
        default: state <= WL_IDLE;
      endcase
    end
  end

  assign mrw_req      = req_q;
  assign mrw_lvl_on   = lvl_q;
  assign mrw_rank     = rank_q;
  assign strobe_pulse = (state == WL_PULSE);
  assign tap_out      = tap_out_q;
  assign busy         = (state != WL_IDLE);
  assign done         = done_q;
  assign fail         = fail_q;
  assign lane_fail    = lfail_q;

  // R2
  mrw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mrw_req && !mrw_ack) |=> mrw_req);

  // R2
  mrw_strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mrw_req && strobe_pulse));

  // R3
  pulse_tap_stable_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_pulse |-> $stable(tap_out));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/wrlvl_seq_tb.sv
module wrlvl_seq_tb_top;
  localparam int NL = 2;
  localparam int TW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cal_start = 1'b0;
  logic          cal_rank = 1'b0;
  logic [7:0]    settle_cycles = 8'd0;
  logic          mrw_req, mrw_lvl_on, mrw_rank;
  logic          mrw_ack = 1'b0;
  logic          strobe_pulse;
  logic [NL*TW-1:0] tap_out;
  logic [NL-1:0] dq_fb;
  logic          busy, done, fail;
  logic [NL-1:0] lane_fail;
  logic          rd_rank = 1'b0;
  logic [NL*TW-1:0] rd_taps;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wrlvl_seq dut_i (
    .clk(clk), .rst(rst), .cal_start(cal_start), .cal_rank(cal_rank),
    .settle_cycles(settle_cycles), .mrw_req(mrw_req), .mrw_lvl_on(mrw_lvl_on),
    .mrw_rank(mrw_rank), .mrw_ack(mrw_ack), .strobe_pulse(strobe_pulse),
    .tap_out(tap_out), .dq_fb(dq_fb), .busy(busy), .done(done), .fail(fail),
    .lane_fail(lane_fail), .rd_rank(rd_rank), .rd_taps(rd_taps)
  );

  // feedback model: number of ones among the 5 pulses at a tap
  int lane_mode [NL];
  int lane_edge [NL];
  int pk = 0;

  function automatic int ones_for(int mode, int edge_t, int tap);
    case (mode)
      0: return (tap < edge_t) ? 2 : 3;
      1: return (tap >= 20 && tap < 30) || tap >= 60 ? 5 : 0;
      2: return 0;
      3: return 5;
      default: return (tap < 10) ? 5 : (tap >= 50 ? 4 : 0);
    endcase
  endfunction

  always_comb begin
    for (int l = 0; l < NL; l++)
      dq_fb[l] = (pk < ones_for(lane_mode[l], lane_edge[l], int'(tap_out[l*TW +: TW])));
  end

  always @(posedge clk) pk <= strobe_pulse ? pk + 1 : 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected value from requirements R4-R7
  function automatic int exp_final(int mode, int edge_t, output bit lf);
    bit prev = 1'b1;
    for (int t = 0; t < 128; t++) begin
      bit v = ones_for(mode, edge_t, t) >= 3;
      if (t > 0 && !prev && v) begin
        lf = 1'b0;
        return (t + 32) % 128;
      end
      prev = v;
    end
    lf = 1'b1;
    return 0;
  endfunction

  typedef struct {
    int         rank;
    int         fin [NL];
    logic [NL-1:0] lf;
  } exp_t;
  exp_t exp_q[$];
  int   stored [2][NL];

  // mode-register write responder and log
  int mrw_n = 0;
  int mrw_lvl [4];
  int mrw_rk  [4];
  int wcnt = 0;
  int pulses = 0;
  int pulses_at_ack = 0;
  int tap_err = 0;
  int gap_err = 0;
  int gap = 0;
  int cur_settle = 0;
  logic [TW-1:0] last_tap = '0;

  initial forever begin
    @(negedge clk);
    mrw_ack = 1'b0;
    if (mrw_req) begin
      wcnt++;
      if (wcnt == 3) begin
        wcnt = 0;
        mrw_ack = 1'b1;
        if (mrw_n < 4) begin
          mrw_lvl[mrw_n] = mrw_lvl_on;
          mrw_rk[mrw_n]  = mrw_rank;
        end
        if (mrw_lvl_on) pulses_at_ack = pulses;
        mrw_n++;
      end
    end
  end

  // sweep monitor (R3)
  initial forever begin
    @(negedge clk);
    if (tap_out[TW-1:0] != last_tap) gap = 0;
    else gap++;
    last_tap = tap_out[TW-1:0];
    if (strobe_pulse) begin
      for (int l = 0; l < NL; l++)
        if (int'(tap_out[l*TW +: TW]) != pulses / 5) tap_err++;
      if (pulses % 5 == 0 && pulses > 0 && gap < cur_settle) gap_err++;
      pulses++;
    end
  end

  // result monitor: pops an expected item at each done
  initial forever begin
    @(negedge clk);
    if (done) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected done", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check(mrw_n == 2, "R11 mrw count", mrw_n, 2);
        check(mrw_lvl[0] == 1 && mrw_rk[0] == e.rank, "R2 enter write rank", mrw_rk[0], e.rank);
        check(pulses_at_ack == 0, "R2 pulses before ack", pulses_at_ack, 0);
        check(mrw_lvl[1] == 0 && mrw_rk[1] == e.rank, "R10 exit write", mrw_lvl[1], 0);
        check(pulses == 640, "R3 pulse count", pulses, 640);
        check(tap_err == 0, "R3 tap order", tap_err, 0);
        check(gap_err == 0, "R3 settle gap", gap_err, 0);
        for (int l = 0; l < NL; l++)
          check(int'(tap_out[l*TW +: TW]) == e.fin[l], "R6 final tap", int'(tap_out[l*TW +: TW]), e.fin[l]);
        check(lane_fail == e.lf, "R7 lane_fail", lane_fail, e.lf);
        check(fail == (|e.lf), "R7 fail", fail, |e.lf);
        for (int l = 0; l < NL; l++) stored[e.rank][l] = e.fin[l];
      end
    end
  end

  task automatic run_cal(int rank, int settle, int m0, int e0, int m1, int e1, bit poke);
    exp_t e;
    lane_mode[0] = m0; lane_edge[0] = e0;
    lane_mode[1] = m1; lane_edge[1] = e1;
    e.rank = rank;
    for (int l = 0; l < NL; l++) begin
      bit lf;
      e.fin[l] = exp_final(lane_mode[l], lane_edge[l], lf);
      e.lf[l]  = lf;
    end
    exp_q.push_back(e);
    mrw_n = 0; pulses = 0; tap_err = 0; gap_err = 0; cur_settle = settle;
    @(negedge clk);
    cal_rank = rank[0]; settle_cycles = 8'(settle); cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    if (poke) begin
      repeat (50) @(negedge clk);
      cal_rank = ~rank[0]; cal_start = 1'b1;   // R11: ignored while busy
      @(negedge clk);
      cal_start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic readback(int rank);
    @(negedge clk);
    rd_rank = rank[0];
    @(negedge clk);
    for (int l = 0; l < NL; l++)
      check(int'(rd_taps[l*TW +: TW]) == stored[rank][l], "R9 readback", int'(rd_taps[l*TW +: TW]), stored[rank][l]);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin lane_mode[l] = 2; lane_edge[l] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!mrw_req && !strobe_pulse && !busy && !done && !fail && lane_fail == 0 && tap_out == 0,
          "R1 reset state", int'(tap_out), 0);
    // R4 R6 R8: threshold edges at 40 and 110 (wraps to 14)
    run_cal(0, 0, 0, 40, 0, 110, 1'b0);
    // R5 R7 R11: second transition ignored, lane 1 never rises
    run_cal(1, 3, 1, 0, 2, 0, 1'b1);
    readback(0);
    // R5 R7: high at tap 0 is no transition; high-low-high pattern
    run_cal(1, 7, 3, 0, 4, 0, 1'b0);
    readback(1);
    readback(0);
    check(exp_q.size() == 0, "R10 all runs done", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule